// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cluster

This block is a soft model of one programmable logic cluster. It holds a set of logic elements. Each element is a k-input lookup table followed by a flip-flop, and a per-element mode bit picks whether the element drives its registered value or its combinational table value. The elements are tied together by a depopulated intracluster network made of small, fully populated crossbars. Downward crossbars feed the element inputs. Each downward crossbar serves one pair of elements and can reach only its own slice of the cluster inputs plus the flip-flop feedback of every element. An upward crossbar gathers all element outputs and chooses which of them leave the cluster, through an output register.

All programming state sits in one serial configuration chain. The chain takes one bit per clock while the configuration enable is high. While that enable is high the cluster outputs read 0 and the element flip-flops hold their value. After the enable drops, the cluster computes with the loaded function.

Top module: `lut_cluster`

## Requirements
- R1: With its mode bit at 0, a logic element's output equals bit `idx` of its 2^K-bit table, where `idx` is formed from the element's K inputs with input 0 as the least significant bit.
- R2: With its mode bit at 1, a logic element outputs its flip-flop. Outside configuration, that flip-flop captures the table value on each rising edge, so the element output lags the table result by one cycle.
- R3: Downward crossbar j serves elements 2j and 2j+1. Its output o drives input (o mod K) of element 2j + o/K. A select value s below GRP (the cluster input count divided by the pair count) picks cluster input j*GRP+s. A value GRP+f picks the flip-flop of element f. Any larger value gives 0.
- R4: An element can reach no cluster input outside the slice of its own pair. Changing those other inputs leaves its output unchanged.
- R5: Cluster output o carries the output of the element named by its upward select. A value of N_LE or more gives 0.
- R6: Cluster outputs are registered and show the upward crossbar result one cycle after the inputs that produce it.
- R7: While cfg_en is high, each rising edge shifts cfg_din into bit 0 of the chain and moves every chain bit up one place. cfg_dout shows the chain's top bit. The chain layout, from bit 0 upward, is: per element i, 2^K table bits at i*(2^K+1), then its mode bit; then the downward selects, ordered by pair and then by crossbar output; then the upward selects, ordered by cluster output. Downward selects are clog2(GRP+N_LE) bits wide and upward selects are clog2(N_LE) bits wide.
- R8: After any edge at which cfg_en is high, every cluster output is 0.
- R9: Element flip-flops keep their value on edges where cfg_en is high.
- R10: A synchronous active-high reset clears the element flip-flops, the cluster outputs and the whole configuration chain.
- R11: While cfg_en is low, the configuration chain and cfg_dout do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable; freezes the logic while high |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Top bit of the configuration chain |
| clu_in | input | N_IN | Cluster input signals |
| clu_out | output | N_OUT | Registered cluster outputs |

## Verification
The hardest case to reach is reprogramming while element flip-flops hold live feedback state. The bench must show that a second configuration pass leaves that state untouched and that the state then reappears at the outputs through feedback and registered paths. To get there, the stimulus runs random inputs on a random configuration until the flip-flops are mixed. It then reloads the same configuration mid-run and carries on comparing against a bench model whose flip-flops freeze during the load. A directed configuration ties one element to its pair's input slice, so that toggling the other pair's inputs shows the limited reach of the tree.

// File: rtl/lutclu_pkg.sv
package lutclu_pkg;
  // bits that one logic element takes in the configuration chain
  function automatic int le_cfg_bits(input int k);
    return (1 << k) + 1;
  endfunction

  // width of a crossbar select that must address m sources
  function automatic int sel_bits(input int m);
    return (m > 1) ? $clog2(m) : 1;
  endfunction
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] bits,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst)
      bits <= '0;
    else if (shift_en)
      bits <= {bits[W-2:0], din};
  end

  assign dout = bits[W-1];
endmodule

// File: rtl/mini_xbar.sv
module mini_xbar #(
  parameter int M  = 8,
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic [M-1:0]    data,
  input  logic [N*SW-1:0] sel,
  output logic [N-1:0]    y
);
  localparam int PADW = 1 << SW;

  logic [PADW-1:0] padded;

  always_comb begin
    padded = '0;
    padded[M-1:0] = data;
  end

  for (genvar n = 0; n < N; n++) begin : g_mux
    assign y[n] = padded[sel[n*SW +: SW]];
  end
endmodule

// File: rtl/logic_elem.sv
module logic_elem #(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [K-1:0]      sel,
  input  logic [(1<<K)-1:0] tbl,
  input  logic              mode_reg,
  output logic              q,
  output logic              y
);
  logic lut_v;

  assign lut_v = tbl[sel];

  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (!hold)
      q <= lut_v;
  end

  assign y = mode_reg ? q : lut_v;
endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
  import lutclu_pkg::*;
#(
  parameter int N_LE  = 4,
  parameter int K     = 4,
  parameter int N_IN  = 8,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic [N_IN-1:0]  clu_in,
  output logic [N_OUT-1:0] clu_out
);
  localparam int NPAIR = N_LE / 2;
  localparam int GRP   = N_IN / NPAIR;
  localparam int DM    = GRP + N_LE;
  localparam int DN    = 2 * K;
  localparam int DSW   = sel_bits(DM);
  localparam int USW   = sel_bits(N_LE);
  localparam int LEW   = le_cfg_bits(K);
  localparam int TBLW  = 1 << K;
  localparam int DB    = N_LE * LEW;
  localparam int UB    = DB + NPAIR * DN * DSW;
  localparam int CW    = UB + N_OUT * USW;

  logic [CW-1:0]     cfg_bits;
  logic [N_LE-1:0]   le_ff;
  logic [N_LE-1:0]   le_out;
  logic [N_LE*K-1:0] le_in;
  logic [N_OUT-1:0]  up_sel;

  cfg_chain #(.W(CW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .bits     (cfg_bits),
    .dout     (cfg_dout)
  );

  // downward tree: one crossbar per element pair, own input slice plus all feedback
  for (genvar j = 0; j < NPAIR; j++) begin : g_down
    mini_xbar #(.M(DM), .N(DN), .SW(DSW)) u_dx (
      .data ({le_ff, clu_in[j*GRP +: GRP]}),
      .sel  (cfg_bits[DB + j*DN*DSW +: DN*DSW]),
      .y    (le_in[j*DN +: DN])
    );
  end

  for (genvar i = 0; i < N_LE; i++) begin : g_le
    logic_elem #(.K(K)) u_le (
      .clk      (clk),
      .rst      (rst),
      .hold     (cfg_en),
      .sel      (le_in[i*K +: K]),
      .tbl      (cfg_bits[i*LEW +: TBLW]),
      .mode_reg (cfg_bits[i*LEW + TBLW]),
      .q        (le_ff[i]),
      .y        (le_out[i])
    );
  end

  // upward crossbar gathering every element output
  mini_xbar #(.M(N_LE), .N(N_OUT), .SW(USW)) u_up (
    .data (le_out),
    .sel  (cfg_bits[UB +: N_OUT*USW]),
    .y    (up_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_en)
      clu_out <= '0;
    else
      clu_out <= up_sel;
  end
endmodule

// File: rtl/lut_cluster_chk.sv
module lut_cluster_chk #(
  parameter int N_LE  = 4,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_dout,
  input logic [N_OUT-1:0] clu_out,
  input logic [N_LE-1:0]  le_ff
);
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (clu_out == '0));

  p_ff_hold_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(le_ff));

  p_chain_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_dout));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (clu_out == '0 && le_ff == '0 && !cfg_dout));
endmodule

bind lut_cluster lut_cluster_chk #(.N_LE(N_LE), .N_OUT(N_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_en   (cfg_en),
  .cfg_dout (cfg_dout),
  .clu_out  (clu_out),
  .le_ff    (le_ff)
);

// File: tb/tb_lut_cluster.sv
module tb_lut_cluster;
  localparam int CLK_P = 10;
  localparam int NLE = 4, K = 4, NIN = 8, NOUT = 4;
  localparam int NP = 2, GRP = 4, DN = 8, DSW = 3, USW = 2;
  localparam int LEW = 17, DB = 68, UB = 116, CW = 124;

  logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0;
  logic cfg_dout;
  logic [NIN-1:0] clu_in = '0;
  logic [NOUT-1:0] clu_out;

  always #(CLK_P/2) clk = ~clk;

  lut_cluster #(.N_LE(NLE), .K(K), .N_IN(NIN), .N_OUT(NOUT)) dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .clu_in(clu_in), .clu_out(clu_out)
  );

  int checks = 0, errors = 0;

  logic [15:0]    lut_t  [NLE];
  logic           mode_t [NLE];
  logic [DSW-1:0] dsel_t [NP][DN];
  logic [USW-1:0] usel_t [NOUT];

  logic [NLE-1:0]  ffm  = '0;
  logic [NOUT-1:0] outm = '0;
  logic [CW-1:0]   chm  = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pack_cfg();
    logic [CW-1:0] v = '0;
    for (int i = 0; i < NLE; i++) begin
      v[i*LEW +: 16] = lut_t[i];
      v[i*LEW + 16]  = mode_t[i];
    end
    for (int j = 0; j < NP; j++)
      for (int o = 0; o < DN; o++)
        v[DB + (j*DN + o)*DSW +: DSW] = dsel_t[j][o];
    for (int o = 0; o < NOUT; o++)
      v[UB + o*USW +: USW] = usel_t[o];
    return v;
  endfunction

  task automatic eval(output logic [NLE-1:0] lv, output logic [NLE-1:0] lo);
    for (int i = 0; i < NLE; i++) begin
      logic [K-1:0] idx;
      for (int b = 0; b < K; b++) begin
        int j, s;
        j = i / 2;
        s = int'(dsel_t[j][(i % 2)*K + b]);
        if (s < GRP)           idx[b] = clu_in[j*GRP + s];
        else if (s < GRP+NLE)  idx[b] = ffm[s - GRP];
        else                   idx[b] = 1'b0;
      end
      lv[i] = lut_t[i][idx];
      lo[i] = mode_t[i] ? ffm[i] : lv[i];
    end
  endtask

  task automatic cyc(input string tag);
    logic [NLE-1:0] lv, lo;
    eval(lv, lo);
    @(posedge clk);
    if (rst) begin
      ffm = '0; outm = '0; chm = '0;
    end else if (cfg_en) begin
      chm = {chm[CW-2:0], cfg_din};
      outm = '0;
    end else begin
      ffm = lv;
      for (int o = 0; o < NOUT; o++) outm[o] = lo[usel_t[o]];
    end
    @(negedge clk);
    check({tag, " clu_out"}, 32'(clu_out), 32'(outm));
    check({tag, " cfg_dout"}, 32'(cfg_dout), 32'(chm[CW-1]));
  endtask

  task automatic load_cfg(input string tag);
    logic [CW-1:0] v = pack_cfg();
    cfg_en = 1'b1;
    for (int b = CW-1; b >= 0; b--) begin
      cfg_din = v[b];
      cyc({tag, " R7 R8 R9"});
    end
    cfg_en = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < NLE; i++) begin
      lut_t[i]  = 16'($urandom);
      mode_t[i] = 1'($urandom);
    end
    for (int j = 0; j < NP; j++)
      for (int o = 0; o < DN; o++) dsel_t[j][o] = DSW'($urandom);
    for (int o = 0; o < NOUT; o++) usel_t[o] = USW'($urandom);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_dummy;
    logic o0;
    seed_dummy = int'($urandom(32'd4711));
    rand_cfg();
    @(negedge clk);
    cyc("R10 reset");
    cyc("R10 reset");
    rst = 1'b0;

    // directed: LE0 xor of slice0 (comb), LE1 same registered, LE2 follows LE0 ff, LE3 follows in[4]
    for (int o = 0; o < K; o++) begin
      dsel_t[0][o]   = DSW'(o);
      dsel_t[0][K+o] = DSW'(o);
      dsel_t[1][o]   = 3'd0;
      dsel_t[1][K+o] = 3'd0;
    end
    dsel_t[1][0] = 3'd4;
    lut_t[0] = 16'h6996; mode_t[0] = 1'b0;
    lut_t[1] = 16'h6996; mode_t[1] = 1'b1;
    lut_t[2] = 16'hAAAA; mode_t[2] = 1'b0;
    lut_t[3] = 16'hAAAA; mode_t[3] = 1'b0;
    for (int o = 0; o < NOUT; o++) usel_t[o] = USW'(o);
    load_cfg("directed");
    clu_in = 8'b0000_0101;
    cyc("R1 R3 R6");
    clu_in[0] = 1'b1;
    cyc("R1 R2 R3 R6");
    cyc("R2 R3 feedback");
    o0 = clu_out[0];
    for (int t = 0; t < 6; t++) begin
      clu_in[7:4] = 4'($urandom);
      cyc("R4");
      check("R4 out-of-slice reach", 32'(clu_out[0]), 32'(o0));
    end
    usel_t[3] = 2'd0;
    load_cfg("R5 reselect");
    for (int t = 0; t < 20; t++) begin
      clu_in = 8'($urandom);
      cyc("R1 R2 R3 R5 R6");
    end

    for (int r = 0; r < 4; r++) begin
      rand_cfg();
      load_cfg("random");
      for (int t = 0; t < 300; t++) begin
        clu_in = 8'($urandom);
        if (r == 1 && t == 150) load_cfg("R9 reload live");
        if (r == 2 && t == 150) begin
          rst = 1'b1;
          cyc("R10 mid reset");
          rst = 1'b0;
          load_cfg("after reset");
        end
        cyc("R1 R2 R3 R5 R6 R11");
      end
    end
    finish_run();
  end
endmodule